// File: doc/BRIEF.md
# Timer Compare Toggle Channel

This block is one compare channel that hangs off a shared free-running 16-bit timer. Software loads a 16-bit compare value and a mode byte through a small write-enable/address/data register port. With the channel armed, the match logic itself inverts an output pin on the exact cycle that the timer equals the compare value. No interrupt handler sits in that path, so interrupt latency has no effect on where the edge lands. When the compare value is left alone, the next edge comes one full timer wrap later.

Each match also sets a sticky flag, and an optional interrupt request is derived from that flag. The compare value is updated in two byte writes. Writing the low byte disarms the comparator and writing the high byte arms it again, so a half-updated value can never produce a match. The timer value and its run enable are registered once on entry, and the comparison is made on those registered copies.

Top module: `timer_compare_toggle`

## Requirements
- R1: After reset, pinOut is 1, matchFlag and irqOut are 0, and every register reads back as 0.
- R2: A match exists when the registered timer run enable is 1, mode bit 6 (arm) is 1, mode bit 3 (match enable) is 1, and the registered timer equals the 16-bit compare value. If mode bit 2 (toggle) is also 1, pinOut inverts. The inversion is seen after the second rising edge that follows the edge presenting the timer value.
- R3: A match with mode bit 2 clear sets matchFlag and leaves pinOut unchanged.
- R4: No match is detected while timerRun is 0, even when the timer equals the compare value.
- R5: A write to address 0 loads the compare low byte and clears mode bit 6. A write to address 1 loads the compare high byte and sets mode bit 6.
- R6: matchFlag stays set until a write to address 3 with data bit 0 equal to 0. A write to address 3 with data bit 0 equal to 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R7: irqOut equals matchFlag ANDed with mode bit 0 (interrupt enable).
- R8: A write to address 2 loads mode bits 6..0. regRdata shows the addressed register combinationally: address 0 is compare low, 1 is compare high, 2 is the mode byte with bit 7 reading 0, and 3 is the flag in bit 0.
- R9: When mode bit 6 or mode bit 3 is 0, equality sets no flag and toggles nothing.
- R10: With the compare value unchanged, a counting timer toggles the pin again after it wraps and returns to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Shared timer value |
| timerRun | input | 1 | Shared timer run enable |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data for the addressed register |
| pinOut | output | 1 | Toggling compare output |
| matchFlag | output | 1 | Sticky match flag |
| irqOut | output | 1 | Interrupt request |

## Verification
Several rules are checked by the assertions on every cycle:
- The pin changes only after a toggle-enabled match.
- The flag rises only after a match.
- Nothing moves while the timer is stopped.
- A low-byte write always disarms and a high-byte write always arms.
- The interrupt is never raised without the flag.

Other behaviour can only be shown by the bench's scenarios. These are the exact two-edge latency of a toggle, a toggle repeating after a full wrap of a counting timer, the outcome when a flag clear and a match coincide, and the readback of each register.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int BYTE_W = 8;

  // register addresses
  localparam logic [1:0] ADDR_CMP_LO = 2'd0;
  localparam logic [1:0] ADDR_CMP_HI = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;
  localparam logic [1:0] ADDR_FLAG   = 2'd3;

  // mode bit positions
  localparam int MB_ARM   = 6;
  localparam int MB_CAPP  = 5;
  localparam int MB_CAPN  = 4;
  localparam int MB_MATCH = 3;
  localparam int MB_TOG   = 2;
  localparam int MB_PWM   = 1;
  localparam int MB_IEN   = 0;
  localparam int MODE_W   = 7;

  typedef struct packed {
    logic              wrLo;
    logic              wrHi;
    logic              wrMode;
    logic              clrFlag;
    logic [BYTE_W-1:0] data;
  } strobeT;
endpackage

// File: rtl/tct_ctrl.sv
module tct_ctrl
  import tct_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output strobeT            strb
);
  always_comb begin
    strb         = '0;
    strb.data    = regWdata;
    strb.wrLo    = regWe && (regAddr == ADDR_CMP_LO);
    strb.wrHi    = regWe && (regAddr == ADDR_CMP_HI);
    strb.wrMode  = regWe && (regAddr == ADDR_MODE);
    strb.clrFlag = regWe && (regAddr == ADDR_FLAG) && !regWdata[0];
  end

  // at most one register strobe per cycle (R5, R6, R8)
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLo, strb.wrHi, strb.wrMode, strb.clrFlag}));
endmodule

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               timerRun,
  input  strobeT             strb,
  input  logic [ADDR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0]  regRdata,
  output logic               pinOut,
  output logic               matchFlag,
  output logic               irqOut
);
  localparam int HI_W = TIMER_W - BYTE_W;

  logic [TIMER_W-1:0] timerQ;
  logic               runQ;
  logic [BYTE_W-1:0]  cmpLoQ;
  logic [HI_W-1:0]    cmpHiQ;
  logic [MODE_W-1:0]  modeQ;
  logic               flagQ;
  logic               pinQ;
  logic               hit;

  // timer sampled once per clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
      runQ   <= 1'b0;
    end else begin
      timerQ <= timerVal;
      runQ   <= timerRun;
    end
  end

  assign hit = runQ && modeQ[MB_ARM] && modeQ[MB_MATCH] &&
               (timerQ == {cmpHiQ, cmpLoQ});

  // compare and mode registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpLoQ <= '0;
      cmpHiQ <= '0;
      modeQ  <= '0;
    end else begin
      if (strb.wrMode) modeQ <= strb.data[MODE_W-1:0];
      if (strb.wrLo) begin
        cmpLoQ        <= strb.data;
        modeQ[MB_ARM] <= 1'b0;
      end
      if (strb.wrHi) begin
        cmpHiQ        <= strb.data[HI_W-1:0];
        modeQ[MB_ARM] <= 1'b1;
      end
    end
  end

  // sticky flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)             flagQ <= 1'b0;
    else if (hit)          flagQ <= 1'b1;
    else if (strb.clrFlag) flagQ <= 1'b0;
  end

  // output pin
  always_ff @(posedge clk) begin
    if (!rstN)                      pinQ <= 1'b1;
    else if (hit && modeQ[MB_TOG])  pinQ <= ~pinQ;
  end

  always_comb begin
    case (regAddr)
      ADDR_CMP_LO: regRdata = cmpLoQ;
      ADDR_CMP_HI: regRdata = BYTE_W'(cmpHiQ);
      ADDR_MODE:   regRdata = {1'b0, modeQ};
      default:     regRdata = {{(BYTE_W-1){1'b0}}, flagQ};
    endcase
  end

  assign pinOut    = pinQ;
  assign matchFlag = flagQ;
  assign irqOut    = flagQ && modeQ[MB_IEN];

  // pin moves only after a toggle-enabled match
  assert_pin_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinQ) |-> $past(runQ && modeQ[MB_ARM] && modeQ[MB_MATCH] &&
                             modeQ[MB_TOG] && timerQ == {cmpHiQ, cmpLoQ}));
  // flag rises only after a match
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(runQ && modeQ[MB_ARM] && modeQ[MB_MATCH] &&
                           timerQ == {cmpHiQ, cmpLoQ}));
  // stopped timer: nothing changes on the next edge
  assert_no_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> $stable(pinQ));
  // low-byte write disarms, high-byte write arms
  assert_lo_disarm_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> !modeQ[MB_ARM]);
  assert_hi_arm_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHi |=> modeQ[MB_ARM]);
  // disarmed channel cannot raise the flag
  assert_disarmed_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ[MB_ARM] && !flagQ) |=> !flagQ);
  // interrupt never without flag
  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> matchFlag);
endmodule

// File: rtl/timer_compare_toggle.sv
module timer_compare_toggle
  import tct_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               timerRun,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BYTE_W-1:0]  regWdata,
  output logic [BYTE_W-1:0]  regRdata,
  output logic               pinOut,
  output logic               matchFlag,
  output logic               irqOut
);
  strobeT strb;

  tct_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb)
  );

  tct_datapath #(.TIMER_W(TIMER_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .timerRun(timerRun),
    .strb(strb), .regAddr(regAddr), .regRdata(regRdata),
    .pinOut(pinOut), .matchFlag(matchFlag), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_timer_compare_toggle.sv
`timescale 1ns/1ps
module sim_timer_compare_toggle;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerVal = '0;
  logic        timerRun = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        pinOut, matchFlag, irqOut;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic        expPin = 1'b1, expFlag = 1'b0, pendHit = 1'b0, lastRun = 1'b0;
  logic [15:0] expCmp = '0, lastV = '0;
  logic [6:0]  expMode = '0;

  always #10 clk = ~clk;

  timer_compare_toggle u0 (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .timerRun(timerRun),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pinOut(pinOut), .matchFlag(matchFlag), .irqOut(irqOut)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic hitFn(input logic [15:0] tv, input logic run);
    return run && expMode[6] && expMode[3] && (tv == expCmp);
  endfunction

  // one cycle: apply pending effect, check, compute next, drive
  task automatic stepCycle(input logic [15:0] tv, input logic run, input string req);
    @(negedge clk);
    if (pendHit) begin
      expFlag = 1'b1;
      if (expMode[2]) expPin = ~expPin;
    end
    check(pinOut === expPin, req, pinOut, expPin);
    check(matchFlag === expFlag, "R6", matchFlag, expFlag);
    check(irqOut === (expFlag & expMode[0]), "R7", irqOut, expFlag & expMode[0]);
    pendHit  = hitFn(lastV, lastRun);
    timerVal = tv;
    timerRun = run;
    lastV    = tv;
    lastRun  = run;
  endtask

  task automatic flush();
    stepCycle(lastV, 1'b0, "R2");
    stepCycle(lastV, 1'b0, "R2");
  endtask

  // must be called after flush (timer stopped)
  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 regWe = 1'b0;
    case (a)
      2'd0: begin expCmp[7:0] = d; expMode[6] = 1'b0; end
      2'd1: begin expCmp[15:8] = d; expMode[6] = 1'b1; end
      2'd2: expMode = d[6:0];
      default: if (!d[0]) expFlag = 1'b0;
    endcase
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1 check(regRdata === exp, req, regRdata, exp);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(pinOut === 1'b1, "R1", pinOut, 1);
    check(matchFlag === 1'b0, "R1", matchFlag, 0);
    check(irqOut === 1'b0, "R1", irqOut, 0);
    for (int a = 0; a < 4; a++) readCheck(2'(a), 8'h00, "R1");

    // R5 / R8 arming and readback
    writeReg(2'd2, 8'hFF);
    readCheck(2'd2, 8'h7F, "R8");
    writeReg(2'd0, 8'h34);
    readCheck(2'd2, 8'h3F, "R5");
    readCheck(2'd0, 8'h34, "R8");
    writeReg(2'd1, 8'h12);
    readCheck(2'd2, 8'h7F, "R5");
    readCheck(2'd1, 8'h12, "R8");

    // R2 directed toggle, exact latency
    writeReg(2'd2, 8'h4D);
    stepCycle(16'h1233, 1'b1, "R2");
    stepCycle(16'h1234, 1'b1, "R2");
    stepCycle(16'h1235, 1'b1, "R2");
    stepCycle(16'h1236, 1'b1, "R2");
    flush();
    readCheck(2'd3, 8'h01, "R8");

    // R6 clear with bit0=1 ignored, then real clear
    writeReg(2'd3, 8'h01);
    readCheck(2'd3, 8'h01, "R6");
    writeReg(2'd3, 8'h00);
    readCheck(2'd3, 8'h00, "R6");

    // R4 no match while stopped
    stepCycle(16'h1234, 1'b0, "R4");
    stepCycle(16'h1234, 1'b0, "R4");
    stepCycle(16'h0000, 1'b0, "R4");
    flush();

    // R6 match coinciding with clear: set wins
    @(negedge clk);
    timerVal = 16'h1234; timerRun = 1'b1;
    @(negedge clk);
    timerVal = 16'h0000;
    regWe = 1'b1; regAddr = 2'd3; regWdata = 8'h00;
    @(posedge clk);
    #1 regWe = 1'b0;
    @(negedge clk);
    expPin = ~expPin; expFlag = 1'b1;
    check(matchFlag === 1'b1, "R6", matchFlag, 1);
    check(pinOut === expPin, "R2", pinOut, expPin);
    lastV = 16'h0000; lastRun = 1'b1; pendHit = 1'b0;
    flush();
    writeReg(2'd3, 8'h00);

    // R3 match without toggle
    writeReg(2'd2, 8'h48);
    stepCycle(16'h1234, 1'b1, "R3");
    stepCycle(16'h0001, 1'b1, "R3");
    flush();
    check(matchFlag === 1'b1 && pinOut === expPin, "R3", matchFlag, 1);
    writeReg(2'd3, 8'h00);

    // R9 disarmed / match disabled
    writeReg(2'd2, 8'h44);
    stepCycle(16'h1234, 1'b1, "R9");
    flush();
    writeReg(2'd2, 8'h0C);
    stepCycle(16'h1234, 1'b1, "R9");
    flush();
    check(matchFlag === 1'b0, "R9", matchFlag, 0);

    // R10 counting timer wraps and matches again
    writeReg(2'd2, 8'h4C);
    writeReg(2'd0, 8'h10);
    writeReg(2'd1, 8'h00);
    for (int i = 0; i < 65536 + 40; i++) stepCycle(16'(i), 1'b1, "R10");
    flush();
    writeReg(2'd3, 8'h00);

    // constrained random batches (R2 R3 R4 R7 R9)
    for (int b = 0; b < 40; b++) begin
      logic [15:0] c;
      logic [7:0]  m;
      c = 16'($urandom);
      m = 8'($urandom) | 8'h08;
      writeReg(2'd2, m);
      writeReg(2'd0, c[7:0]);
      writeReg(2'd1, c[15:8]);
      if ($urandom_range(0, 3) == 0) writeReg(2'd0, c[7:0]);
      for (int i = 0; i < 60; i++) begin
        int    sel;
        logic [15:0] tv;
        sel = $urandom_range(0, 3);
        tv = (sel == 0) ? c : (sel == 1) ? c + 16'd1 : 16'($urandom);
        stepCycle(tv, $urandom_range(0, 4) != 0, "R2");
        if ($urandom_range(0, 15) == 0) begin
          flush();
          writeReg(2'd3, 8'($urandom_range(0, 1)));
        end
      end
      flush();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule